// File: doc/BRIEF.md
# Half-Bridge Gate Drive Protection Controller

This block is the clocked decision logic for one leg of a half bridge. It takes a turn-on command for the lower switch and another for the upper switch. It also takes comparator flags for each side: overcurrent or desaturation, positive rail below its trip level, and negative rail above its trip level. From these it produces a gate enable for each switch, a sense-node clamp enable for each switch, one merged active-low fault indication and a gated charge-pump clock. The analog comparators, the isolation link, the output stages and deadtime generation all sit outside the block. The fault state of the upper side reaches this logic as a single status bit on the return channel.

Every asynchronous flag and command passes through a two-stage synchronizer. Each side has its own small state machine. The state machine holds the gate register, the overcurrent latch and a command edge detector. A cross-conduction interlock links the two sides. A divider derives the charge-pump clock from the system clock, and a rail-overstress flag stops it.

Top module: `hb_guard_top`

## Requirements
- R1: With no fault and the other side's command low, a gate output goes high on the third rising clock edge after its command pin goes high, and goes low on the third edge after the command pin goes low.
- R2: A gate may turn on only in a cycle where the other side's synchronized command is low. The two gate outputs are never high together. A gate that is already on stays on while the other command is raised.
- R3: If both commands rise together from the all-off state, both gates stay off for as long as both commands are held. When one command is released, the other side turns on.
- R4: The overcurrent flag of a side is ignored while that side's gate is off. It latches nothing, does not pull fault_n_o low and does not stop a later turn-on.
- R5: An overcurrent flag while a gate is on drives that gate low within three clock edges of the pin (30 ns at 100 MHz) and latches a fault. The gate then stays off, even with the command still high and the flag gone. Only the next rising edge of that side's command clears the latch.
- R6: Either undervoltage flag of a side holds that gate off and pulls fault_n_o low for as long as the flag is present. Neither is latched. When the flag clears, the gate returns to its command with no new command edge.
- R7: While reset is active, and afterwards until the positive-rail undervoltage flag has been seen clear, both gates are off and fault_n_o is low.
- R8: fault_n_o is low exactly when either side has a latched overcurrent fault or a present undervoltage flag, or when the upper-side status bit (hi_stat_i) is high. The status bit never changes either gate.
- R9: Each clamp output is high exactly when that side's gate output is low.
- R10: With rail_over_i low, pump_clk_o toggles every round(CLK_HZ / (2*PUMP_HZ)) cycles, which is 83 cycles for the defaults (about 600 kHz). From the third edge after rail_over_i goes high, pump_clk_o is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lo_i | input | 1 | Lower switch command, high = on |
| cmd_hi_i | input | 1 | Upper switch command, high = on |
| oc_lo_i | input | 1 | Lower side overcurrent/desaturation flag |
| oc_hi_i | input | 1 | Upper side overcurrent/desaturation flag |
| vpos_uv_lo_i | input | 1 | Lower side positive rail below trip |
| vneg_uv_lo_i | input | 1 | Lower side negative rail above trip |
| vpos_uv_hi_i | input | 1 | Upper side positive rail below trip |
| vneg_uv_hi_i | input | 1 | Upper side negative rail above trip |
| hi_stat_i | input | 1 | Upper side fault status from return channel |
| rail_over_i | input | 1 | Rail-to-rail difference exceeds 20 V |
| gate_lo_o | output | 1 | Lower gate enable |
| gate_hi_o | output | 1 | Upper gate enable |
| fault_n_o | output | 1 | Merged fault, low = fault (drives open-drain pull-down) |
| clamp_lo_o | output | 1 | Short lower sense node |
| clamp_hi_o | output | 1 | Short upper sense node |
| pump_clk_o | output | 1 | Gated charge-pump clock |

## Verification
Suppose an overcurrent latch failed to hold or failed to clear. The gate would then come back without a fresh command edge, or would stay dead after one. fault_n_o would show the same error within one cycle of the latch. If the interlock or edge-detector state were wrong, both gates could be high in the same cycle, and the bench's per-cycle comparison against its own model would report that at the next falling edge. A wrong synchronizer reset value would show as a gate or fault_n_o change in the first two cycles after reset.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;
  // positions inside the synchronized input vector
  localparam int IX_CMD   = 0;  // 2 bits: lo, hi
  localparam int IX_OC    = 2;  // 2 bits: lo, hi
  localparam int IX_UV    = 4;  // 4 bits: pos lo, neg lo, pos hi, neg hi
  localparam int IX_STAT  = 8;
  localparam int IX_RAIL  = 9;
  localparam int N_SYNC   = 10;

  // undervoltage and rail overstress come up asserted so outputs stay off
  localparam logic [N_SYNC-1:0] SYNC_RST = 10'b10_1111_0000;

  // cycles per half period of the pump clock, rounded
  function automatic int unsigned pump_half(input int unsigned clk_hz,
                                            input int unsigned pump_hz);
    return (clk_hz + pump_hz) / (2 * pump_hz);
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_side.sv
module hb_side (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd,        // synchronized own command
  input  logic cmd_other,  // synchronized command of opposite side
  input  logic oc,         // synchronized overcurrent flag
  input  logic uv,         // synchronized undervoltage (either rail)
  output logic gate_o,
  output logic clamp_o,
  output logic oc_lat_o,
  output logic rise_o,
  output logic fault_o
);
  logic cmd_d, gate_q, lat_q;
  logic rise, oc_trip, lat_eff, gate_nx, lat_nx;

  assign rise    = cmd & ~cmd_d;
  assign oc_trip = gate_q & oc;          // sensing only while on
  assign lat_eff = lat_q & ~rise;        // a fresh edge clears the latch

  always_comb begin
    if (rise)         lat_nx = 1'b0;
    else if (oc_trip) lat_nx = 1'b1;
    else              lat_nx = lat_q;
  end

  // turn-on needs the other command low; holding on does not
  assign gate_nx = cmd & ~(lat_eff | oc_trip | uv) & (gate_q | ~cmd_other);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d  <= 1'b0;
      gate_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      cmd_d  <= cmd;
      gate_q <= gate_nx;
      lat_q  <= lat_nx;
    end
  end

  assign gate_o   = gate_q;
  assign clamp_o  = ~gate_q;
  assign oc_lat_o = lat_q;
  assign rise_o   = rise;
  assign fault_o  = lat_q | uv;
endmodule

// File: rtl/hb_pump.sv
module hb_pump #(
  parameter int unsigned HALF = 83
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  output logic pclk_o
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          pclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pclk <= 1'b0;
    end else if (stop) begin
      cnt  <= '0;
      pclk <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      pclk <= ~pclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  assign pclk_o = pclk;
endmodule

// File: rtl/hb_guard_top.sv
module hb_guard_top #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned PUMP_HZ     = 600_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_lo_i,
  input  logic cmd_hi_i,
  input  logic oc_lo_i,
  input  logic oc_hi_i,
  input  logic vpos_uv_lo_i,
  input  logic vneg_uv_lo_i,
  input  logic vpos_uv_hi_i,
  input  logic vneg_uv_hi_i,
  input  logic hi_stat_i,
  input  logic rail_over_i,
  output logic gate_lo_o,
  output logic gate_hi_o,
  output logic fault_n_o,
  output logic clamp_lo_o,
  output logic clamp_hi_o,
  output logic pump_clk_o
);
  import hb_guard_pkg::*;

  localparam int unsigned HALF = pump_half(CLK_HZ, PUMP_HZ);

  logic [N_SYNC-1:0] raw, syn;
  logic [1:0] cmd_s, oc_s, uv_s;
  logic       stat_s, rail_s;
  logic [1:0] gate_v, clamp_v, oc_lat_v, rise_v, fault_v;

  assign raw = {rail_over_i, hi_stat_i,
                vneg_uv_hi_i, vpos_uv_hi_i, vneg_uv_lo_i, vpos_uv_lo_i,
                oc_hi_i, oc_lo_i, cmd_hi_i, cmd_lo_i};

  hb_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  assign cmd_s   = syn[IX_CMD +: 2];
  assign oc_s    = syn[IX_OC +: 2];
  assign uv_s[0] = syn[IX_UV]     | syn[IX_UV + 1];
  assign uv_s[1] = syn[IX_UV + 2] | syn[IX_UV + 3];
  assign stat_s  = syn[IX_STAT];
  assign rail_s  = syn[IX_RAIL];

  for (genvar i = 0; i < 2; i++) begin : g_side
    hb_side u_side (
      .clk(clk), .rst_n(rst_n),
      .cmd(cmd_s[i]), .cmd_other(cmd_s[1-i]),
      .oc(oc_s[i]), .uv(uv_s[i]),
      .gate_o(gate_v[i]), .clamp_o(clamp_v[i]),
      .oc_lat_o(oc_lat_v[i]), .rise_o(rise_v[i]), .fault_o(fault_v[i]));
  end

  hb_pump #(.HALF(HALF)) u_pump (
    .clk(clk), .rst_n(rst_n), .stop(rail_s), .pclk_o(pump_clk_o));

  assign gate_lo_o  = gate_v[0];
  assign gate_hi_o  = gate_v[1];
  assign clamp_lo_o = clamp_v[0];
  assign clamp_hi_o = clamp_v[1];
  assign fault_n_o  = ~(|fault_v | stat_s);
endmodule

// File: rtl/hb_guard_chk.sv
module hb_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd_s,
  input logic [1:0] oc_s,
  input logic [1:0] uv_s,
  input logic       stat_s,
  input logic       rail_s,
  input logic [1:0] gate_v,
  input logic [1:0] oc_lat_v,
  input logic [1:0] rise_v,
  input logic       fault_n_o,
  input logic       pump_clk_o
);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_v[0] && gate_v[1]));

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_s |-> !fault_n_o);

  p_pump_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rail_s |=> !pump_clk_o);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    p_rise_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_v[i]) |-> $past(cmd_s[i]));

    p_interlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_v[i]) |-> !$past(cmd_s[1-i]));

    p_oc_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_v[i] && !oc_lat_v[i]) |=> !oc_lat_v[i]);

    p_oc_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_v[i] && oc_s[i]) |=> (!gate_v[i] && oc_lat_v[i]));

    p_oc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_lat_v[i] && !rise_v[i]) |=> (oc_lat_v[i] && !gate_v[i]));

    p_uv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      uv_s[i] |=> !gate_v[i]);
  end
endmodule

bind hb_guard_top hb_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_s(cmd_s), .oc_s(oc_s), .uv_s(uv_s),
  .stat_s(stat_s), .rail_s(rail_s), .gate_v(gate_v), .oc_lat_v(oc_lat_v),
  .rise_v(rise_v), .fault_n_o(fault_n_o), .pump_clk_o(pump_clk_o));

// File: tb/sim_hb_guard_top.sv
module sim_hb_guard_top;
  localparam time PERIOD = 10ns;
  localparam int unsigned F_CLK  = 100_000_000;
  localparam int unsigned F_PUMP = 600_000;
  // pin vector positions: 0 cmd_lo,1 cmd_hi,2 oc_lo,3 oc_hi,4 vpos_lo,5 vneg_lo,
  // 6 vpos_hi,7 vneg_hi,8 hi_stat,9 rail_over
  localparam logic [9:0] PWRUP = 10'b10_1111_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] pins = 10'b10_0001_0000;
  logic gate_lo, gate_hi, fault_n, clamp_lo, clamp_hi, pump;
  int checks = 0, fails = 0;
  logic model_on = 1'b0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  hb_guard_top u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_lo_i(pins[0]), .cmd_hi_i(pins[1]), .oc_lo_i(pins[2]), .oc_hi_i(pins[3]),
    .vpos_uv_lo_i(pins[4]), .vneg_uv_lo_i(pins[5]),
    .vpos_uv_hi_i(pins[6]), .vneg_uv_hi_i(pins[7]),
    .hi_stat_i(pins[8]), .rail_over_i(pins[9]),
    .gate_lo_o(gate_lo), .gate_hi_o(gate_hi), .fault_n_o(fault_n),
    .clamp_lo_o(clamp_lo), .clamp_hi_o(clamp_hi), .pump_clk_o(pump));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int half_cycles(input int unsigned fc, input int unsigned fp);
    return (int'(fc / 100_000) * 10 / int'(2 * fp / 100_000) + 5) / 10;
  endfunction

  // reference model written from the requirements: {gate_next, latch_next}
  function automatic logic [1:0] side_next(input logic cmd, input logic other,
      input logic cmd_prev, input logic gate, input logic lat, input logic oc,
      input logic uv);
    logic edge_up, trip, keep_lat, g;
    edge_up  = cmd && !cmd_prev;
    trip     = gate && oc;
    keep_lat = lat && !edge_up;
    g = cmd && !keep_lat && !trip && !uv && (gate || !other);
    return {g, edge_up ? 1'b0 : (trip ? 1'b1 : lat)};
  endfunction

  logic [9:0] m_s1, m_s2;
  logic [1:0] m_cmdd, m_gate, m_lat;
  logic [1:0] nx0, nx1;
  always_comb begin
    nx0 = side_next(m_s2[0], m_s2[1], m_cmdd[0], m_gate[0], m_lat[0], m_s2[2],
                    m_s2[4] | m_s2[5]);
    nx1 = side_next(m_s2[1], m_s2[0], m_cmdd[1], m_gate[1], m_lat[1], m_s2[3],
                    m_s2[6] | m_s2[7]);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= PWRUP; m_s2 <= PWRUP;
      m_cmdd <= '0; m_gate <= '0; m_lat <= '0;
    end else begin
      m_s1 <= pins; m_s2 <= m_s1;
      m_cmdd <= m_s2[1:0];
      m_gate <= {nx1[1], nx0[1]};
      m_lat  <= {nx1[0], nx0[0]};
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      logic exp_fn;
      exp_fn = !(m_lat[0] | m_lat[1] | m_s2[4] | m_s2[5] | m_s2[6] | m_s2[7] | m_s2[8]);
      chk(gate_lo == m_gate[0], "R1 model gate_lo", gate_lo, m_gate[0]);
      chk(gate_hi == m_gate[1], "R1 model gate_hi", gate_hi, m_gate[1]);
      chk(!(gate_lo && gate_hi), "R2 overlap", 1, 0);
      chk(clamp_lo == !gate_lo && clamp_hi == !gate_hi, "R9 clamp",
          {clamp_hi, clamp_lo}, {!gate_hi, !gate_lo});
      chk(fault_n == exp_fn, "R8 model fault_n", fault_n, exp_fn);
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hc, cnt;
    hc = half_cycles(F_CLK, F_PUMP);
    step(3);
    // reset state (R7)
    chk(!gate_lo && !gate_hi, "R7 reset gates", {gate_hi, gate_lo}, 0);
    chk(clamp_lo && clamp_hi, "R9 reset clamps", {clamp_hi, clamp_lo}, 3);
    chk(!fault_n, "R7 reset fault_n", fault_n, 0);
    chk(!pump, "R10 reset pump", pump, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    // R7: command while positive rail still low
    pins[0] = 1'b1; step(10);
    chk(!gate_lo, "R7 held off in undervoltage", gate_lo, 0);
    chk(!fault_n, "R7 fault during power-up", fault_n, 0);
    pins[4] = 1'b0; step(2);
    chk(!gate_lo, "R1 latency not before third edge", gate_lo, 0);
    step(1);
    chk(gate_lo && fault_n, "R7 on after supply good", {gate_lo, fault_n}, 3);
    // R2 interlock
    pins[1] = 1'b1; step(10);
    chk(gate_lo && !gate_hi, "R2 hi blocked while lo cmd", {gate_hi, gate_lo}, 1);
    chk(!clamp_lo && clamp_hi, "R9 clamps follow gates", {clamp_hi, clamp_lo}, 2);
    pins[0] = 1'b0; step(3);
    chk(!gate_lo && gate_hi, "R2 hi on after lo released", {gate_hi, gate_lo}, 2);
    // R3 simultaneous rise from all off
    pins[1] = 1'b0; step(5);
    pins[1:0] = 2'b11; step(10);
    chk(!gate_lo && !gate_hi, "R3 both held off", {gate_hi, gate_lo}, 0);
    pins[1] = 1'b0; step(3);
    chk(gate_lo && !gate_hi, "R3 lo on after hi release", {gate_hi, gate_lo}, 1);
    // R4 sense ignored while off
    pins[0] = 1'b0; step(5);
    pins[2] = 1'b1; step(6);
    chk(fault_n && !gate_lo, "R4 oc while off ignored", {fault_n, gate_lo}, 2);
    pins[2] = 1'b0; step(3);
    pins[0] = 1'b1; step(3);
    chk(gate_lo && fault_n, "R4 later turn-on unaffected", {gate_lo, fault_n}, 3);
    // R5 latch and clear
    pins[2] = 1'b1; step(3);
    chk(!gate_lo, "R5 off within 3 edges", gate_lo, 0);
    chk(!fault_n, "R5 fault reported", fault_n, 0);
    pins[2] = 1'b0; step(10);
    chk(!gate_lo && !fault_n, "R5 latched with cmd high", {gate_lo, fault_n}, 0);
    pins[0] = 1'b0; step(3);
    chk(!fault_n, "R5 falling cmd does not clear", fault_n, 0);
    pins[0] = 1'b1; step(3);
    chk(gate_lo && fault_n, "R5 cleared by cmd rise", {gate_lo, fault_n}, 3);
    // R6 undervoltage on high side
    pins[0] = 1'b0; step(3);
    pins[1] = 1'b1; step(3);
    chk(gate_hi, "R1 hi follows cmd", gate_hi, 1);
    pins[7] = 1'b1; step(3);
    chk(!gate_hi && !fault_n, "R6 neg rail uv holds off", {gate_hi, fault_n}, 0);
    pins[7] = 1'b0; step(3);
    chk(gate_hi && fault_n, "R6 resumes without edge", {gate_hi, fault_n}, 3);
    pins[6] = 1'b1; step(3);
    chk(!gate_hi, "R6 pos rail uv holds off", gate_hi, 0);
    pins[6] = 1'b0; step(3);
    // R8 status bit
    pins[8] = 1'b1; step(2);
    chk(!fault_n, "R8 status pulls fault low", fault_n, 0);
    chk(gate_hi && !gate_lo, "R8 status leaves gates", {gate_hi, gate_lo}, 2);
    pins[8] = 1'b0; step(2);
    chk(fault_n, "R8 status released", fault_n, 1);
    // R10 pump
    pins[9] = 1'b0;
    cnt = 0;
    while (!pump && cnt < 400) begin step(1); cnt++; end
    cnt = 0;
    while (pump && cnt < 400) begin step(1); cnt++; end
    chk(cnt == hc, "R10 high half period", cnt, hc);
    cnt = 0;
    while (!pump && cnt < 400) begin step(1); cnt++; end
    chk(cnt == hc, "R10 low half period", cnt, hc);
    pins[9] = 1'b1; step(3);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin step(1); if (pump) cnt++; end
    chk(cnt == 0, "R10 gated while overstress", cnt, 0);
    // random phase against the model
    pins = '0;
    void'($urandom(32'h1ab5));
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if ($urandom % 8 == 0)   pins[0] = ~pins[0];
      if ($urandom % 8 == 0)   pins[1] = ~pins[1];
      pins[2] = ($urandom % 12 == 0);
      pins[3] = ($urandom % 12 == 0);
      if ($urandom % 150 == 0) pins[4] = ~pins[4];
      if ($urandom % 150 == 0) pins[5] = ~pins[5];
      if ($urandom % 150 == 0) pins[6] = ~pins[6];
      if ($urandom % 150 == 0) pins[7] = ~pins[7];
      if ($urandom % 40 == 0)  pins[8] = ~pins[8];
    end
    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule